// File: doc/BRIEF.md
# Return Address Stack with Interrupt Gating

This block keeps the return addresses of a small processor core. It holds 12-bit program counter values for six levels of nesting. Software cannot read or write them. When the core executes a subroutine call, it raises `call_i` with the current program counter on `pc_i`, and the block saves that value. When the core executes a return, it raises `ret_i`. In that same cycle the most recent saved address appears on `ret_pc_o`, and the block then drops it. Instruction decode sits outside the block.

The block also decides when an interrupt may be taken. It has two sources: a time base tick and a real-time clock tick. Each source's request strobe sets a pending flag. A pending flag whose source is enabled is acknowledged only when three things hold: the stack has a free level, and neither a call nor a return occupies that cycle. On acknowledge the block pushes `pc_i`, drives the source's vector address on `vec_o` and raises `ack_o`.

While the stack is full, interrupts wait and their requests stay latched. A call on a full stack does not wait: it pushes anyway, discards the oldest address, and so keeps the six newest.

Top module: `retstack_irq`

## Requirements
- R1: After reset the stack holds no entries, both pending flags are clear, `ack_o` is low and `vec_o` is zero.
- R2: A cycle with `call_i` high saves `pc_i`. A cycle with `ret_i` high shows the most recently saved address on `ret_pc_o` in that same cycle and removes it, so addresses come back last-in first-out. `call_i` and `ret_i` are never high together.
- R3: The stack has six levels. A call while six entries are held discards the oldest entry, so the six newest addresses remain in order.
- R4: A return while the stack is empty leaves the depth at zero, and the value on `ret_pc_o` is undefined. A later call and return still behave as on a fresh stack.
- R5: A one-cycle request strobe sets that source's pending flag, and the flag holds until the source is acknowledged. While a source's enable is low, its pending flag is never acknowledged but is kept.
- R6: An acknowledge occurs in any cycle in which all of the following hold: an enabled source is pending, fewer than six entries are held, and neither `call_i` nor `ret_i` is high. The acknowledge saves `pc_i` like a call.
- R7: While the stack is full, `ack_o` stays low and the request stays pending. After a return frees a level, the held interrupt is acknowledged in the next idle cycle.
- R8: During an acknowledge, `vec_o` is 12'h014 for the time base source and 12'h018 for the real-time clock source. When there is no acknowledge, `vec_o` is zero.
- R9: The time base source wins when both are pending and enabled. Only the acknowledged source's flag is cleared. If a new strobe from that source arrives in the acknowledge cycle, its flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| call_i | input | 1 | Subroutine call strobe: save `pc_i` |
| ret_i | input | 1 | Return strobe: remove the newest entry |
| pc_i | input | 12 | Program counter value to save on call or acknowledge |
| tb_req_i | input | 1 | Time base interrupt request strobe |
| rtc_req_i | input | 1 | Real-time clock interrupt request strobe |
| tb_en_i | input | 1 | Time base interrupt enable |
| rtc_en_i | input | 1 | Real-time clock interrupt enable |
| ret_pc_o | output | 12 | Newest saved address, valid in a return cycle |
| vec_o | output | 12 | Vector address during an acknowledge, else zero |
| ack_o | output | 1 | Interrupt acknowledge |

## Verification
The assertions check several rules on every cycle. The depth never exceeds six. No acknowledge happens when the stack is full or when a call or return is under way. A ready, enabled time base request is always acknowledged. The vector is always legal, and it is the time base vector whenever that source is ready. Request strobes always set their flags.

Some behaviour only the bench scenarios can show. These are the order of returned addresses and the loss of the oldest entry on a full-stack call. They also include recovery after a return on an empty stack, and the delayed acknowledge once a return frees a level. The bench checks these against a queue model in a directed pass and a long random pass.

// File: rtl/retstack_pkg.sv
package retstack_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_TB   = 2'd1,
    SRC_RTC  = 2'd2
  } irq_src_e;
endpackage

// File: rtl/rs_ptr.sv
// Top-of-stack index and occupancy for a circular return stack.
module rs_ptr #(
  parameter int DEPTH = 6,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] top_idx_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] top_q, top_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             upd;

  assign full_o   = (cnt_q == CNT_W'(DEPTH));
  assign empty_o  = (cnt_q == '0);
  assign rd_idx_o = (top_q == '0) ? LAST : top_q - 1'b1;

  // next state: push wraps over the oldest slot once full
  always_comb begin
    top_n = top_q;
    cnt_n = cnt_q;
    upd   = 1'b0;
    if (push_i) begin
      top_n = (top_q == LAST) ? '0 : top_q + 1'b1;
      if (!full_o) cnt_n = cnt_q + 1'b1;
      upd = 1'b1;
    end else if (pop_i && !empty_o) begin
      top_n = rd_idx_o;
      cnt_n = cnt_q - 1'b1;
      upd   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      top_q <= top_n;
      cnt_q <= cnt_n;
    end
  end

  assign top_idx_o = top_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/rs_mem.sv
// Storage entries for the return stack, one register per level.
module rs_mem #(
  parameter int DEPTH = 6,
  parameter int PC_W  = 12,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PC_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PC_W-1:0]  rd_data_o
);
  logic [PC_W-1:0] ent_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [PC_W-1:0] q;
    logic            we;
    assign we = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (we) q <= wr_data_i;
    end
    assign ent_w[g] = q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_i == IDX_W'(i)) rd_data_o = ent_w[i];
    end
  end
endmodule

// File: rtl/rs_irq.sv
// Pending flags, fixed-priority arbitration and vector selection.
module rs_irq #(
  parameter int              PC_W    = 12,
  parameter logic [PC_W-1:0] VEC_TB  = 12'h014,
  parameter logic [PC_W-1:0] VEC_RTC = 12'h018
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tb_req_i,
  input  logic            rtc_req_i,
  input  logic            tb_en_i,
  input  logic            rtc_en_i,
  input  logic            grant_ok_i,
  output logic            ack_o,
  output logic [PC_W-1:0] vec_o,
  output logic            tb_pend_o,
  output logic            rtc_pend_o
);
  import retstack_pkg::*;

  logic     tb_pend_q, tb_pend_n;
  logic     rtc_pend_q, rtc_pend_n;
  irq_src_e src;

  always_comb begin
    src = SRC_NONE;
    if (grant_ok_i) begin
      if (tb_pend_q && tb_en_i)        src = SRC_TB;
      else if (rtc_pend_q && rtc_en_i) src = SRC_RTC;
    end
  end

  always_comb begin
    unique case (src)
      SRC_TB:  vec_o = VEC_TB;
      SRC_RTC: vec_o = VEC_RTC;
      default: vec_o = '0;
    endcase
  end

  assign ack_o = (src != SRC_NONE);

  // a fresh strobe in the acknowledge cycle wins over the clear
  assign tb_pend_n  = tb_req_i  | (tb_pend_q  & (src != SRC_TB));
  assign rtc_pend_n = rtc_req_i | (rtc_pend_q & (src != SRC_RTC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_pend_q  <= 1'b0;
      rtc_pend_q <= 1'b0;
    end else begin
      tb_pend_q  <= tb_pend_n;
      rtc_pend_q <= rtc_pend_n;
    end
  end

  assign tb_pend_o  = tb_pend_q;
  assign rtc_pend_o = rtc_pend_q;
endmodule

// File: rtl/retstack_irq.sv
// Return address stack with interrupt acknowledge gating.
module retstack_irq #(
  parameter int                DEPTH   = 6,
  parameter int                PC_W    = 12,
  parameter logic [PC_W-1:0]   VEC_TB  = 12'h014,
  parameter logic [PC_W-1:0]   VEC_RTC = 12'h018,
  localparam int               IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int               CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            tb_req_i,
  input  logic            rtc_req_i,
  input  logic            tb_en_i,
  input  logic            rtc_en_i,
  output logic [PC_W-1:0] ret_pc_o,
  output logic [PC_W-1:0] vec_o,
  output logic            ack_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [IDX_W-1:0] top_idx, rd_idx;
  logic [CNT_W-1:0] cnt;
  logic             full, empty;
  logic             grant_ok, push;
  logic             tb_pend, rtc_pend;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign grant_ok = !full && !call_i && !ret_i;
  assign push     = call_i || ack_o;

  rs_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push_i    (push),
    .pop_i     (ret_i),
    .top_idx_o (top_idx),
    .rd_idx_o  (rd_idx),
    .cnt_o     (cnt),
    .full_o    (full),
    .empty_o   (empty)
  );

  rs_mem #(.DEPTH(DEPTH), .PC_W(PC_W)) u_mem (
    .clk       (clk),
    .wr_en_i   (push),
    .wr_idx_i  (top_idx),
    .wr_data_i (pc_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (ret_pc_o)
  );

  rs_irq #(.PC_W(PC_W), .VEC_TB(VEC_TB), .VEC_RTC(VEC_RTC)) u_irq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tb_req_i   (tb_req_i),
    .rtc_req_i  (rtc_req_i),
    .tb_en_i    (tb_en_i),
    .rtc_en_i   (rtc_en_i),
    .grant_ok_i (grant_ok),
    .ack_o      (ack_o),
    .vec_o      (vec_o),
    .tb_pend_o  (tb_pend),
    .rtc_pend_o (rtc_pend)
  );
endmodule

// File: rtl/retstack_irq_chk.sv
// Property checker, attached to every retstack_irq instance.
module retstack_irq_chk #(
  parameter int              DEPTH   = 6,
  parameter int              PC_W    = 12,
  parameter logic [PC_W-1:0] VEC_TB  = 12'h014,
  parameter logic [PC_W-1:0] VEC_RTC = 12'h018,
  localparam int             CNT_W   = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            call_i,
  input logic            ret_i,
  input logic            tb_req_i,
  input logic            rtc_req_i,
  input logic            tb_en_i,
  input logic            ack_o,
  input logic [PC_W-1:0] vec_o,
  input logic [CNT_W-1:0] cnt,
  input logic            full,
  input logic            empty,
  input logic            tb_pend,
  input logic            rtc_pend
);
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH)); // R3
  AST_FULL_CALL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && full) |=> full); // R3
  AST_OP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(call_i && ret_i)); // R2
  AST_CALL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !full) |=> (cnt == $past(cnt) + 1'b1)); // R2
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && empty) |=> empty); // R4
  AST_REQ_TB_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    tb_req_i |=> tb_pend); // R5
  AST_REQ_RTC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_req_i |=> rtc_pend); // R5
  AST_NO_ACK_ON_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i || ret_i) |-> !ack_o); // R6
  AST_ACK_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && !call_i && !ret_i && tb_pend && tb_en_i) |-> ack_o); // R6
  AST_NO_ACK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !ack_o); // R7
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (vec_o == VEC_TB || vec_o == VEC_RTC)); // R8
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |-> (vec_o == '0)); // R8
  AST_TB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && tb_pend && tb_en_i) |-> (vec_o == VEC_TB)); // R9
  AST_TB_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && vec_o == VEC_TB && !tb_req_i) |=> !tb_pend); // R9
endmodule

bind retstack_irq retstack_irq_chk #(
  .DEPTH(DEPTH), .PC_W(PC_W), .VEC_TB(VEC_TB), .VEC_RTC(VEC_RTC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .call_i    (call_i),
  .ret_i     (ret_i),
  .tb_req_i  (tb_req_i),
  .rtc_req_i (rtc_req_i),
  .tb_en_i   (tb_en_i),
  .ack_o     (ack_o),
  .vec_o     (vec_o),
  .cnt       (cnt),
  .full      (full),
  .empty     (empty),
  .tb_pend   (tb_pend),
  .rtc_pend  (rtc_pend)
);

// File: tb/retstack_irq_test.sv
module retstack_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 6;
  localparam logic [11:0] V_TB  = 12'h014;
  localparam logic [11:0] V_RTC = 12'h018;

  logic        clk, rst_n;
  logic        call_i, ret_i, tb_req_i, rtc_req_i, tb_en_i, rtc_en_i;
  logic [11:0] pc_i, ret_pc_o, vec_o;
  logic        ack_o;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;

  int unsigned stk[$];
  bit          m_tbp, m_rtcp;

  retstack_irq uut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .pc_i(pc_i),
    .tb_req_i(tb_req_i), .rtc_req_i(rtc_req_i), .tb_en_i(tb_en_i),
    .rtc_en_i(rtc_en_i), .ret_pc_o(ret_pc_o), .vec_o(vec_o), .ack_o(ack_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check before the next rising edge, update model
  task automatic cyc(input bit call, input bit ret, input bit tbr, input bit rtcr,
                     input bit tben, input bit rtcen, input logic [11:0] pc,
                     input string tag, input bit quiet_empty = 1'b0);
    bit          e_ack;
    logic [11:0] e_vec;
    bit          e_tb;
    @(negedge clk);
    call_i = call; ret_i = ret; tb_req_i = tbr; rtc_req_i = rtcr;
    tb_en_i = tben; rtc_en_i = rtcen; pc_i = pc;
    #1;
    e_tb  = m_tbp && tben;
    e_ack = !call && !ret && (stk.size() < DEPTH) && (e_tb || (m_rtcp && rtcen));
    e_vec = !e_ack ? 12'h000 : (e_tb ? V_TB : V_RTC);
    chk(ack_o == e_ack, tag, "ack_o", int'(ack_o), int'(e_ack));
    chk(vec_o == e_vec, tag, "vec_o", int'(vec_o), int'(e_vec));
    if (ret && stk.size() > 0)
      chk(ret_pc_o == stk[$], tag, "ret_pc_o", int'(ret_pc_o), int'(stk[$]));
    else if (ret && !quiet_empty)
      $display("note: %s return on empty stack, value undefined", tag);
    @(posedge clk);
    if (call) begin
      if (stk.size() == DEPTH) void'(stk.pop_front());
      stk.push_back(pc);
    end else if (ret) begin
      if (stk.size() > 0) void'(stk.pop_back());
    end else if (e_ack) begin
      stk.push_back(pc);
      if (e_tb) m_tbp = 1'b0; else m_rtcp = 1'b0;
    end
    if (tbr)  m_tbp  = 1'b1;
    if (rtcr) m_rtcp = 1'b1;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    call_i = 0; ret_i = 0; tb_req_i = 0; rtc_req_i = 0;
    tb_en_i = 1; rtc_en_i = 1; pc_i = '0;
    m_tbp = 0; m_rtcp = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: idle after reset, nothing pending, stack empty
    cyc(0, 0, 0, 0, 1, 1, 12'h0AA, "R1");
    cyc(0, 0, 0, 0, 1, 1, 12'h0AB, "R1");
    chk(stk.size() == 0, "R1", "model depth", stk.size(), 0);

    // R4: return on an empty stack, then normal use
    cyc(0, 1, 0, 0, 1, 1, 12'h000, "R4");
    cyc(1, 0, 0, 0, 1, 1, 12'h3C5, "R4");
    cyc(0, 1, 0, 0, 1, 1, 12'h000, "R4");

    // R2: last-in first-out order
    cyc(1, 0, 0, 0, 1, 1, 12'h100, "R2");
    cyc(1, 0, 0, 0, 1, 1, 12'h200, "R2");
    cyc(1, 0, 0, 0, 1, 1, 12'h300, "R2");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 1, 1, 12'h000, "R2");

    // R3: seven calls keep the six newest, then R4 empty pop after draining
    for (int i = 1; i <= 7; i++) cyc(1, 0, 0, 0, 1, 1, 12'(i * 16 + 1), "R3");
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0, 1, 1, 12'h000, "R3");
    cyc(0, 1, 0, 0, 1, 1, 12'h000, "R4");
    cyc(1, 0, 0, 0, 1, 1, 12'h055, "R4");
    cyc(0, 1, 0, 0, 1, 1, 12'h000, "R4");

    // R5: masked request is held, acknowledged once enabled (R8 vector)
    cyc(0, 0, 0, 1, 1, 0, 12'h010, "R5");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 0, 12'h011, "R5");
    cyc(0, 0, 0, 0, 1, 1, 12'h012, "R8");
    cyc(0, 1, 0, 0, 1, 1, 12'h000, "R6");

    // R7: full stack holds the acknowledge until a return frees a level
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 1, 1, 12'(12'h400 + i), "R7");
    cyc(0, 0, 1, 0, 1, 1, 12'h7F0, "R7");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 1, 12'h7F1, "R7");
    cyc(0, 1, 0, 0, 1, 1, 12'h000, "R7");
    cyc(0, 0, 0, 0, 1, 1, 12'h7F2, "R7");
    cyc(0, 1, 0, 0, 1, 1, 12'h000, "R6");
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 1, 1, 12'h000, "R7");

    // R9: both pending, time base first; re-request during acknowledge
    cyc(0, 0, 1, 1, 1, 1, 12'h020, "R9");
    cyc(0, 0, 1, 0, 1, 1, 12'h021, "R9");
    cyc(0, 0, 0, 0, 1, 1, 12'h022, "R9");
    cyc(0, 0, 0, 0, 1, 1, 12'h023, "R9");
    cyc(0, 0, 0, 0, 1, 1, 12'h024, "R9");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 1, 1, 12'h000, "R9");

    // R6: random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      bit c, rt;
      r  = $urandom_range(0, 99);
      c  = (r < 22);
      rt = (r >= 22 && r < 44);
      cyc(c, rt, ($urandom_range(0, 99) < 6), ($urandom_range(0, 99) < 6),
          ($urandom_range(0, 9) != 0), ($urandom_range(0, 9) != 0),
          12'($urandom), "R6", 1'b1);
    end

    finish_run();
  end
endmodule